// File: doc/BRIEF.md
# Fan Tachometer Period Monitor

This block measures the rotation period of one cooling fan. It counts scaled reference ticks in the interval between two successive rising edges of the fan's tachometer signal. At each rising edge it copies the count into a readable register and starts the next interval from zero. A slow fan gives a large count and a fast fan gives a small one. The count stops at its top value instead of wrapping. When a scaled tick arrives while the count is already at the top value, the block treats this as a stalled or failing fan.

The reference tick is a one-cycle strobe from a slow base oscillator. A 2-bit select divides that strobe by 2, 4, 8 or 16 before counting. This lets software trade resolution against the slowest fan speed that can be measured. An overflow clears an active-low status bit. If fault reporting is enabled, the overflow also raises a request on a shared alert line. The status bit stays low until the host writes a clear.

Top module: `tach_period_mon`

## Requirements
- R1: Between two rising edges of `tachIn`, the running count increases by one for each scaled tick and stops at 255. A later rising edge then loads 255 into `tachCount`.
- R2: `divSel` values 0, 1, 2 and 3 make one scaled tick from 2, 4, 8 and 16 `refTick` strobes. With the strobes counted from a rising edge, `tachCount` equals floor(strobes / divisor).
- R3: A rising edge of `tachIn` loads the running count into `tachCount`. It also restarts both the running count and the prescaler phase from zero. `tachCount` changes at no other time.
- R4: `tachIn` passes through a two-stage synchroniser. The capture for a rising edge happens within three clock edges of the change on `tachIn`.
- R5: An overflow is a scaled tick that arrives while the running count is 255. An overflow with `faultEn` high drives `faultStatusN` to 0. An overflow with `faultEn` low leaves `faultStatusN` at 1.
- R6: `alertReq` is high exactly when a latched fault is present and `faultEn` is high.
- R7: A latched fault keeps `faultStatusN` at 0 through any later rising edges. A one-cycle `faultClr` pulse with no overflow in the same cycle returns it to 1.
- R8: Any change of `divSel` clears the running count and the prescaler phase, so no interval mixes two rates.
- R9: While `rstN` is low and after it is released, `tachCount` is 0, `faultStatusN` is 1 and `alertReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refTick | input | 1 | One-cycle base reference strobe |
| tachIn | input | 1 | Fan tachometer signal, asynchronous |
| divSel | input | 2 | Prescaler select: 0 gives /2, 1 gives /4, 2 gives /8, 3 gives /16 |
| faultEn | input | 1 | Fault reporting enable |
| faultClr | input | 1 | Host clear pulse for the latched fault |
| tachCount | output | 8 | Period count captured at the last rising edge |
| faultStatusN | output | 1 | Fault status, 0 after an enabled overflow |
| alertReq | output | 1 | Request to the shared alert line |

## Verification
The hardest state to reach from the ports is the boundary between saturation and overflow. At that boundary the count sits at 255, but no fault exists until one more scaled tick arrives. The stimulus handles this by holding `refTick` high for exact numbers of cycles after a synchronised rising edge. It uses 2040 strobes at /8 to land exactly on 255 with no fault, and 512 strobes at /2 to go one tick past it. A second test changes `divSel` halfway through an interval, so that a result counted at the mixed rate would differ from the one expected.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
  typedef struct packed {
    logic restart;   // divisor change: flush count and prescaler
    logic capture;   // synchronised rising tach edge
    logic cntTick;   // scaled tick that may advance the count
  } tpm_strobe_t;
endpackage

// File: rtl/tpm_ctrl.sv
module tpm_ctrl
  import tpm_pkg::*;
#(
  parameter int DIV_SEL_W   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 refTick,
  input  logic                 tachIn,
  input  logic [DIV_SEL_W-1:0] divSel,
  output tpm_strobe_t          strb
);
  localparam int PRE_W = 1 << DIV_SEL_W;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   tachPrev;
  logic [DIV_SEL_W-1:0]   divSelQ;
  logic [PRE_W-1:0]       preCnt;
  logic [PRE_W-1:0]       preLast;
  logic                   tachRise;
  logic                   divChange;
  logic                   preWrap;

  // synchroniser chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= tachIn;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[g] <= 1'b0;
      else       syncQ[g] <= syncQ[g-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tachPrev <= 1'b0;
    else       tachPrev <= syncQ[SYNC_STAGES-1];
  end

  assign tachRise  = syncQ[SYNC_STAGES-1] & ~tachPrev;
  assign divChange = (divSel != divSelQ);

  // terminal prescaler value: 2^(divSel+1) - 1
  always_comb begin
    preLast = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i <= int'(divSel)) preLast[i] = 1'b1;
    end
  end

  assign preWrap = refTick && (preCnt == preLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divSelQ <= '0;
      preCnt  <= '0;
    end else begin
      divSelQ <= divSel;
      if (divChange || tachRise) preCnt <= '0;
      else if (preWrap)          preCnt <= '0;
      else if (refTick)          preCnt <= preCnt + 1'b1;
    end
  end

  always_comb begin
    strb.restart = divChange;
    strb.capture = tachRise;
    strb.cntTick = preWrap && !divChange && !tachRise;
  end
endmodule

// File: rtl/tpm_datapath.sv
module tpm_datapath
  import tpm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tpm_strobe_t      strb,
  input  logic             faultEn,
  input  logic             faultClr,
  output logic [CNT_W-1:0] tachCount,
  output logic             faultStatusN,
  output logic             alertReq
);
  logic [CNT_W-1:0] runCnt;
  logic             faultLatched;
  logic             atMax;
  logic             overflow;

  assign atMax    = (runCnt == {CNT_W{1'b1}});
  assign overflow = strb.cntTick && atMax;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt    <= '0;
      tachCount <= '0;
    end else begin
      if (strb.capture) tachCount <= runCnt;
      if (strb.capture || strb.restart) runCnt <= '0;
      else if (strb.cntTick && !atMax)  runCnt <= runCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    faultLatched <= 1'b0;
    else if (overflow && faultEn) faultLatched <= 1'b1;
    else if (faultClr)            faultLatched <= 1'b0;
  end

  assign faultStatusN = ~faultLatched;
  assign alertReq     = faultLatched & faultEn;
endmodule

// File: rtl/tach_period_mon.sv
module tach_period_mon
  import tpm_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int DIV_SEL_W   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 refTick,
  input  logic                 tachIn,
  input  logic [DIV_SEL_W-1:0] divSel,
  input  logic                 faultEn,
  input  logic                 faultClr,
  output logic [CNT_W-1:0]     tachCount,
  output logic                 faultStatusN,
  output logic                 alertReq
);
  tpm_strobe_t strb;

  tpm_ctrl #(.DIV_SEL_W(DIV_SEL_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .refTick(refTick), .tachIn(tachIn),
    .divSel(divSel), .strb(strb)
  );

  tpm_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .faultEn(faultEn),
    .faultClr(faultClr), .tachCount(tachCount),
    .faultStatusN(faultStatusN), .alertReq(alertReq)
  );
endmodule

// File: rtl/tpm_chk.sv
module tpm_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             faultEn,
  input logic             faultClr,
  input logic             faultStatusN,
  input logic [CNT_W-1:0] tachCount,
  input logic             capture,
  input logic             restart,
  input logic [CNT_W-1:0] runCnt
);
  // R5
  fault_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultStatusN) |-> $past(faultEn));

  // R7
  fault_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultStatusN) |-> $past(faultClr));

  // R3
  count_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(tachCount) |-> $past(capture));

  // R3
  capture_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> (tachCount == $past(runCnt)));

  // R8
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (runCnt == '0));

  // R1
  saturate_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runCnt == {CNT_W{1'b1}} && !capture && !restart) |=> (runCnt == {CNT_W{1'b1}}));
endmodule

bind tach_period_mon tpm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .faultEn(faultEn), .faultClr(faultClr),
  .faultStatusN(faultStatusN), .tachCount(tachCount),
  .capture(strb.capture), .restart(strb.restart), .runCnt(u_dp.runCnt)
);

// File: tb/tb_tach_period_mon.sv
module tb_tach_period_mon;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refTick = 1'b0;
  logic       tachIn = 1'b0;
  logic [1:0] divSel = 2'd0;
  logic       faultEn = 1'b1;
  logic       faultClr = 1'b0;
  logic [7:0] tachCount;
  logic       faultStatusN;
  logic       alertReq;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  tach_period_mon dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .tachIn(tachIn),
    .divSel(divSel), .faultEn(faultEn), .faultClr(faultClr),
    .tachCount(tachCount), .faultStatusN(faultStatusN), .alertReq(alertReq)
  );

  localparam int NV = 8;
  localparam int VDIV [NV] = '{0, 1, 2, 3, 0, 3, 2, 1};
  localparam int VTICK[NV] = '{10, 40, 80, 160, 7, 31, 2040, 3};
  localparam int VEXP [NV] = '{5, 10, 10, 10, 3, 1, 255, 0};

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tachPulse();
    tachIn = 1'b1;
    repeat (4) @(negedge clk);
    tachIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      refTick = 1'b1;
      repeat (n) @(negedge clk);
      refTick = 1'b0;
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #2000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 count in reset", tachCount, 0);
    check("R9 status in reset", faultStatusN, 1);
    check("R9 alert in reset", alertReq, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 count after reset", tachCount, 0);

    // R1 R2 R3 vector table
    for (int v = 0; v < NV; v++) begin
      divSel = 2'(VDIV[v]);
      repeat (2) @(negedge clk);
      tachPulse();
      ticks(VTICK[v]);
      tachPulse();
      check("R2 R3 period count", tachCount, VEXP[v]);
      check("R1 no fault at or below 255", faultStatusN, 1);
    end

    // R4 capture latency after a rising edge
    divSel = 2'd0;
    repeat (2) @(negedge clk);
    tachPulse();
    ticks(8);
    tachIn = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 capture within three edges", tachCount, 4);
    tachIn = 1'b0;
    repeat (4) @(negedge clk);

    // R5 R1 overflow at /2
    tachPulse();
    ticks(510);
    check("R5 saturated without overflow", faultStatusN, 1);
    ticks(2);
    check("R5 overflow clears status", faultStatusN, 0);
    check("R6 alert with enable", alertReq, 1);
    tachPulse();
    check("R1 saturated capture", tachCount, 255);

    // R7 latched across later edges
    ticks(6);
    tachPulse();
    check("R7 new count", tachCount, 3);
    check("R7 fault still latched", faultStatusN, 0);

    // R6 enable gates the alert
    faultEn = 1'b0;
    @(negedge clk);
    check("R6 alert masked", alertReq, 0);
    check("R6 status kept", faultStatusN, 0);
    faultEn = 1'b1;
    @(negedge clk);
    check("R6 alert back", alertReq, 1);

    // R7 host clear
    faultClr = 1'b1;
    @(negedge clk);
    faultClr = 1'b0;
    @(negedge clk);
    check("R7 clear restores status", faultStatusN, 1);
    check("R7 clear drops alert", alertReq, 0);

    // R5 overflow ignored when disabled
    faultEn = 1'b0;
    tachPulse();
    ticks(600);
    check("R5 disabled overflow ignored", faultStatusN, 1);
    tachPulse();
    check("R5 disabled alert", alertReq, 0);
    faultEn = 1'b1;

    // R8 divisor change mid interval
    divSel = 2'd0;
    repeat (2) @(negedge clk);
    tachPulse();
    ticks(6);
    divSel = 2'd1;
    repeat (2) @(negedge clk);
    ticks(8);
    tachPulse();
    check("R8 divisor change restarts", tachCount, 2);

    // R3 prescaler phase restarts on edge
    tachPulse();
    ticks(3);
    tachPulse();
    ticks(4);
    tachPulse();
    check("R3 prescaler phase reset", tachCount, 1);

    finishRun();
  end
endmodule